// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block keeps the atomic reservation of one processor context. It sits between the load/store pipeline and the memory system, after address translation. A locked-read request records a reservation on the 16-byte granule that holds its physical address. A later store-conditional to the same granule finds out through this block whether the reservation is still intact. Each store-conditional gets a pass/fail verdict, a 2-bit result code and a flag that says whether the store may go out to memory. An uncacheable store-conditional skips the reservation check altogether and returns its own result code.

Other agents can remove the reservation. A snoop-style invalidate clears it when its address falls in the reserved granule, and a separate clear input drops it whatever the address. The block counts failed cacheable store-conditionals in a row. It raises a one-cycle warning every time that count reaches a multiple of a configurable period, which is 100000 by default, so that software or a debug unit can detect possible livelock. The counter saturates and does not wrap.

The control path is a two-state machine. In IDLE the block is ready and takes a request (transition ACCEPT: IDLE to RESP). In RESP it presents the registered response for exactly one cycle and is not ready (transition RETIRE: RESP to IDLE). Reset forces IDLE.

Top module: `resv_monitor`

## Requirements
- R1: An accepted locked read (req_op = 0) stores the address with its low 4 bits ignored as the reserved granule and sets the reservation. Its response is pass = 1, issue = 1, code = 1.
- R2: A cacheable store-conditional (req_op = 1, req_uncached = 0) succeeds when the reservation is set and its address matches the reserved granule in every bit above bit 3. Its response is pass = 1, issue = 1, code = 1. It also clears the reservation.
- R3: A cacheable store-conditional whose reservation is not set, or whose granule differs, fails. Its response is pass = 0, issue = 0, code = 0, and the reservation is cleared.
- R4: An uncacheable store-conditional always answers pass = 1, issue = 1, code = 2. It leaves both the reservation and the failure count unchanged.
- R5: req_ready is high in IDLE. An accepted request produces rsp_valid exactly one cycle later, for one cycle only, and req_ready is low during that cycle.
- R6: Each failed cacheable store-conditional adds one to the consecutive-failure count, and a successful one resets the count to 0.
- R7: livelock_warn pulses for one cycle, together with the failing response, whenever the count reaches a non-zero multiple of WARN_PERIOD.
- R8: The count saturates at 2^CNT_W - 1. Further failures then raise no warning.
- R9: inv_valid with an address in the reserved granule clears the reservation, and one in any other granule leaves it set.
- R10: lock_clear clears the reservation whatever the address.
- R11: When a locked read is accepted in the same cycle as a matching invalidate or as lock_clear, the reservation ends up set.
- R12: Synchronous reset clears the reservation, the reserved granule and the failure count, and drives rsp_valid and livelock_warn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = locked read, 1 = store-conditional |
| req_uncached | input | 1 | Store-conditional targets uncacheable space |
| req_addr | input | ADDR_W | Physical address of the request |
| inv_valid | input | 1 | External invalidate present |
| inv_addr | input | ADDR_W | Physical address of the invalidate |
| lock_clear | input | 1 | Drop the reservation unconditionally |
| rsp_valid | output | 1 | Response present |
| rsp_pass | output | 1 | Operation passed |
| rsp_issue | output | 1 | Store may be sent to memory |
| rsp_code | output | 2 | 0 fail, 1 success, 2 uncacheable bypass |
| livelock_warn | output | 1 | One-cycle warning of repeated failures |

## Verification
Store-conditionals are tried against several reservation states. These include a matching granule with different low address bits, a neighbouring granule, no reservation at all, and a reservation that an earlier store-conditional, a matching or non-matching invalidate, or lock_clear has already consumed. Together they separate the granule compare from the flag check and from the clear paths. Uncacheable store-conditionals are placed between failing ones, which shows whether the bypass disturbs the reservation or the failure count. Runs of 20 failures, with the period and counter width set small, show where each warning falls. They also tell a reset-on-success counter from one that ignores successes, and a saturating counter from one that wraps.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic {
        OP_LOCK_READ  = 1'b0,
        OP_STORE_COND = 1'b1
    } resv_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resv_state_e;

    localparam logic [1:0] RC_FAIL   = 2'd0;
    localparam logic [1:0] RC_OK     = 2'd1;
    localparam logic [1:0] RC_BYPASS = 2'd2;

    typedef struct packed {
        logic       pass;
        logic       issue;
        logic [1:0] code;
    } resv_rsp_t;

endpackage

// File: rtl/resv_tracker.sv
module resv_tracker #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              drop_en,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              flag_o
);
    localparam int TAG_W = ADDR_W - GRAN_BITS;

    logic             flag_q;
    logic [TAG_W-1:0] tag_q;
    logic             inv_hit;

    assign inv_hit   = inv_valid && (inv_addr[ADDR_W-1:GRAN_BITS] == tag_q);
    assign probe_hit = flag_q && (probe_addr[ADDR_W-1:GRAN_BITS] == tag_q);
    assign flag_o    = flag_q;

    // A new reservation takes priority over any clearing source in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            tag_q  <= '0;
        end else if (set_en) begin
            flag_q <= 1'b1;
            tag_q  <= set_addr[ADDR_W-1:GRAN_BITS];
        end else if (drop_en || inv_hit) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/resv_fail_counter.sv
module resv_fail_counter #(
    parameter int CNT_W       = 24,
    parameter int WARN_PERIOD = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fail_inc,
    input  logic             succ_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             warn_o
);
    localparam int               PH_W    = (WARN_PERIOD > 2) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(WARN_PERIOD - 1);

    logic [CNT_W-1:0] count_q;
    logic [PH_W-1:0]  phase_q;
    logic             warn_q;

    // The phase tracks count modulo WARN_PERIOD, so no divider is needed.
    always_ff @(posedge clk) begin
        if (rst || succ_clr) begin
            count_q <= '0;
            phase_q <= '0;
            warn_q  <= 1'b0;
        end else if (fail_inc && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
            if (phase_q == PH_LAST) begin
                phase_q <= '0;
                warn_q  <= 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
                warn_q  <= 1'b0;
            end
        end else begin
            warn_q <= 1'b0;
        end
    end

    assign count_o = count_q;
    assign warn_o  = warn_q;
endmodule

// File: rtl/resv_seq.sv
module resv_seq
    import resv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  resv_op_e  req_op,
    input  logic      req_uncached,
    input  logic      resv_hit,
    output logic      req_ready,
    output logic      lr_set,
    output logic      sc_consume,
    output logic      sc_fail,
    output logic      sc_succ,
    output logic      rsp_valid,
    output resv_rsp_t rsp
);
    resv_state_e state_q, state_d;
    resv_rsp_t   rsp_q, rsp_d;
    logic        accept;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state: ACCEPT and RETIRE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and request decode
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
        accept     = req_ready && req_valid;
        lr_set     = accept && (req_op == OP_LOCK_READ);
        sc_succ    = accept && (req_op == OP_STORE_COND) && !req_uncached && resv_hit;
        sc_fail    = accept && (req_op == OP_STORE_COND) && !req_uncached && !resv_hit;
        sc_consume = sc_succ || sc_fail;

        rsp_d = rsp_q;
        if (accept) begin
            if (req_op == OP_LOCK_READ)
                rsp_d = '{pass: 1'b1, issue: 1'b1, code: RC_OK};
            else if (req_uncached)
                rsp_d = '{pass: 1'b1, issue: 1'b1, code: RC_BYPASS};
            else if (resv_hit)
                rsp_d = '{pass: 1'b1, issue: 1'b1, code: RC_OK};
            else
                rsp_d = '{pass: 1'b0, issue: 1'b0, code: RC_FAIL};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '{pass: 1'b0, issue: 1'b0, code: RC_FAIL};
        else     rsp_q <= rsp_d;
    end

    assign rsp = rsp_q;
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 4,
    parameter int CNT_W       = 24,
    parameter int WARN_PERIOD = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic              req_uncached,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              lock_clear,
    output logic              rsp_valid,
    output logic              rsp_pass,
    output logic              rsp_issue,
    output logic [1:0]        rsp_code,
    output logic              livelock_warn
);
    logic             resv_hit;
    logic             lock_flag;
    logic             lr_set;
    logic             sc_consume;
    logic             sc_fail;
    logic             sc_succ;
    logic [CNT_W-1:0] fail_count;
    resv_rsp_t        rsp;
    resv_op_e         op;

    assign op = resv_op_e'(req_op);

    resv_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_op       (op),
        .req_uncached (req_uncached),
        .resv_hit     (resv_hit),
        .req_ready    (req_ready),
        .lr_set       (lr_set),
        .sc_consume   (sc_consume),
        .sc_fail      (sc_fail),
        .sc_succ      (sc_succ),
        .rsp_valid    (rsp_valid),
        .rsp          (rsp)
    );

    resv_tracker #(
        .ADDR_W    (ADDR_W),
        .GRAN_BITS (GRAN_BITS)
    ) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .set_en     (lr_set),
        .set_addr   (req_addr),
        .drop_en    (sc_consume || lock_clear),
        .inv_valid  (inv_valid),
        .inv_addr   (inv_addr),
        .probe_addr (req_addr),
        .probe_hit  (resv_hit),
        .flag_o     (lock_flag)
    );

    resv_fail_counter #(
        .CNT_W       (CNT_W),
        .WARN_PERIOD (WARN_PERIOD)
    ) u_fail_cnt (
        .clk      (clk),
        .rst      (rst),
        .fail_inc (sc_fail),
        .succ_clr (sc_succ),
        .count_o  (fail_count),
        .warn_o   (livelock_warn)
    );

    assign rsp_pass  = rsp.pass;
    assign rsp_issue = rsp.issue;
    assign rsp_code  = rsp.code;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_op,
    input logic             rsp_valid,
    input logic             rsp_pass,
    input logic             rsp_issue,
    input logic [1:0]       rsp_code,
    input logic             livelock_warn,
    input logic             lock_flag,
    input logic [CNT_W-1:0] fail_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_rsp_follows_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    assert_rsp_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_busy_during_rsp_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_lock_read_sets_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_op) |=> lock_flag);

    assert_fail_blocks_store_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd0) |-> (!rsp_pass && !rsp_issue));

    assert_bypass_issues_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd2) |-> (rsp_pass && rsp_issue));

    assert_fail_counts_up_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd0 && $past(fail_count) != CNT_MAX)
            |-> (fail_count == $past(fail_count) + 1'b1));

    assert_warn_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        livelock_warn |=> !livelock_warn);

    assert_warn_with_fail_R7: assert property (@(posedge clk) disable iff (rst)
        livelock_warn |-> (rsp_valid && rsp_code == 2'd0));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (fail_count == CNT_MAX) |=> (fail_count == CNT_MAX || fail_count == '0));
endmodule

bind resv_monitor resv_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .rsp_valid     (rsp_valid),
    .rsp_pass      (rsp_pass),
    .rsp_issue     (rsp_issue),
    .rsp_code      (rsp_code),
    .livelock_warn (livelock_warn),
    .lock_flag     (lock_flag),
    .fail_count    (fail_count)
);

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic          req_uncached = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          inv_valid = 1'b0;
    logic [AW-1:0] inv_addr = '0;
    logic          lock_clear = 1'b0;
    logic          rsp_valid, rsp_pass, rsp_issue, livelock_warn;
    logic [1:0]    rsp_code;

    int checks = 0;
    int errors = 0;

    // code layout: {pass, issue, code[1:0]}
    localparam logic [3:0] EXP_OK   = 4'b1101;
    localparam logic [3:0] EXP_FAIL = 4'b0000;
    localparam logic [3:0] EXP_BYP  = 4'b1110;

    localparam logic [AW-1:0] A_BASE = 32'h1000_0030;

    always #2 clk = ~clk;

    resv_monitor #(
        .ADDR_W      (AW),
        .GRAN_BITS   (4),
        .CNT_W       (4),
        .WARN_PERIOD (5)
    ) u_resv_monitor (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_uncached  (req_uncached),
        .req_addr      (req_addr),
        .inv_valid     (inv_valid),
        .inv_addr      (inv_addr),
        .lock_clear    (lock_clear),
        .rsp_valid     (rsp_valid),
        .rsp_pass      (rsp_pass),
        .rsp_issue     (rsp_issue),
        .rsp_code      (rsp_code),
        .livelock_warn (livelock_warn)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [3:0] last_rsp;
    logic       last_warn;

    // One request; returns the response and warning seen in the response cycle.
    task automatic send(input logic op, input logic unc, input logic [AW-1:0] addr,
                        input logic with_inv, input logic with_clr);
        @(negedge clk);
        check("R5 ready in idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_op = op; req_uncached = unc; req_addr = addr;
        if (with_inv) begin inv_valid = 1'b1; inv_addr = addr ^ 32'h5; end
        if (with_clr) lock_clear = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; inv_valid = 1'b0; lock_clear = 1'b0;
        check("R5 response after one cycle", 32'(rsp_valid), 32'd1);
        check("R5 not ready during response", 32'(req_ready), 32'd0);
        last_rsp  = {rsp_pass, rsp_issue, rsp_code};
        last_warn = livelock_warn;
        @(negedge clk);
        check("R5 response lasts one cycle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic lock_rd(input logic [AW-1:0] a);
        send(1'b0, 1'b0, a, 1'b0, 1'b0);
    endtask

    task automatic st_cond(input logic [AW-1:0] a);
        send(1'b1, 1'b0, a, 1'b0, 1'b0);
    endtask

    // Brings the failure count back to zero through a successful pair.
    task automatic resync;
        lock_rd(A_BASE);
        st_cond(A_BASE);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R12 rsp_valid low in reset", 32'(rsp_valid), 32'd0);
        check("R12 warn low in reset", 32'(livelock_warn), 32'd0);
        @(negedge clk); rst = 1'b0;
        st_cond(32'h0);
        check("R12 no reservation after reset", 32'(last_rsp), 32'(EXP_FAIL));
    endtask

    task automatic t_lock_and_succeed;
        lock_rd(A_BASE + 32'h4);
        check("R1 locked read response", 32'(last_rsp), 32'(EXP_OK));
        st_cond(A_BASE + 32'hC);
        check("R2 same granule other low bits succeeds", 32'(last_rsp), 32'(EXP_OK));
        st_cond(A_BASE + 32'hC);
        check("R2 success consumed reservation", 32'(last_rsp), 32'(EXP_FAIL));
    endtask

    task automatic t_fail_paths;
        lock_rd(A_BASE);
        st_cond(A_BASE + 32'h10);
        check("R3 neighbour granule fails", 32'(last_rsp), 32'(EXP_FAIL));
        st_cond(A_BASE);
        check("R3 failure cleared reservation", 32'(last_rsp), 32'(EXP_FAIL));
        lock_rd(A_BASE);
        st_cond(A_BASE ^ 32'h8000_0000);
        check("R3 high address bit differs fails", 32'(last_rsp), 32'(EXP_FAIL));
    endtask

    task automatic t_bypass;
        resync;
        repeat (4) st_cond(32'h2000_0000);
        lock_rd(A_BASE);
        send(1'b1, 1'b1, 32'h4000_0000, 1'b0, 1'b0);
        check("R4 uncacheable result", 32'(last_rsp), 32'(EXP_BYP));
        check("R4 uncacheable raises no warning", 32'(last_warn), 32'd0);
        send(1'b1, 1'b1, A_BASE, 1'b0, 1'b0);
        check("R4 uncacheable same granule result", 32'(last_rsp), 32'(EXP_BYP));
        // Reservation must survive both bypasses.
        st_cond(A_BASE);
        check("R4 reservation untouched", 32'(last_rsp), 32'(EXP_OK));
        repeat (4) st_cond(32'h2000_0000);
        send(1'b1, 1'b1, 32'h2000_0000, 1'b0, 1'b0);
        st_cond(32'h2000_0000);
        check("R4 count untouched, warn on fifth failure", 32'(last_warn), 32'd1);
    endtask

    task automatic t_invalidate;
        lock_rd(A_BASE);
        @(negedge clk); inv_valid = 1'b1; inv_addr = A_BASE + 32'h10;
        @(negedge clk); inv_valid = 1'b0;
        st_cond(A_BASE);
        check("R9 other-granule invalidate ignored", 32'(last_rsp), 32'(EXP_OK));
        lock_rd(A_BASE);
        @(negedge clk); inv_valid = 1'b1; inv_addr = A_BASE + 32'h7;
        @(negedge clk); inv_valid = 1'b0;
        st_cond(A_BASE);
        check("R9 matching invalidate clears", 32'(last_rsp), 32'(EXP_FAIL));
    endtask

    task automatic t_clear;
        lock_rd(A_BASE);
        @(negedge clk); lock_clear = 1'b1;
        @(negedge clk); lock_clear = 1'b0;
        st_cond(A_BASE);
        check("R10 clear drops reservation", 32'(last_rsp), 32'(EXP_FAIL));
    endtask

    task automatic t_same_cycle;
        send(1'b0, 1'b0, A_BASE, 1'b1, 1'b0);
        st_cond(A_BASE);
        check("R11 locked read beats invalidate", 32'(last_rsp), 32'(EXP_OK));
        send(1'b0, 1'b0, A_BASE, 1'b0, 1'b1);
        st_cond(A_BASE);
        check("R11 locked read beats clear", 32'(last_rsp), 32'(EXP_OK));
    endtask

    task automatic t_counter_reset;
        resync;
        repeat (3) st_cond(32'h2000_0000);
        resync;
        for (int i = 1; i <= 5; i++) begin
            st_cond(32'h2000_0000);
            check($sformatf("R6 warn after success reset, failure %0d", i),
                  32'(last_warn), 32'(i == 5));
        end
    endtask

    task automatic t_warn_sat;
        resync;
        for (int i = 1; i <= 20; i++) begin
            st_cond(32'h2000_0000);
            if (i <= 15)
                check($sformatf("R7 warn at failure %0d", i), 32'(last_warn),
                      32'(i % 5 == 0));
            else
                check($sformatf("R8 saturated, failure %0d", i), 32'(last_warn), 32'd0);
        end
    endtask

    task automatic t_reset_mid;
        resync;
        repeat (3) st_cond(32'h2000_0000);
        lock_rd(A_BASE);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        st_cond(A_BASE);
        check("R12 reset cleared reservation", 32'(last_rsp), 32'(EXP_FAIL));
        for (int i = 2; i <= 5; i++) begin
            st_cond(32'h2000_0000);
            check($sformatf("R12 count restarted, failure %0d", i), 32'(last_warn),
                  32'(i == 5));
        end
    endtask

    initial begin
        t_reset;
        t_lock_and_succeed;
        t_fail_paths;
        t_bypass;
        t_invalidate;
        t_clear;
        t_same_cycle;
        t_counter_reset;
        t_warn_sat;
        t_reset_mid;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule